// File: doc/BRIEF.md
# Interrupt, Reset and Test Input Conditioner

This block sits beside a processor core and turns four asynchronous control pins into clean, clock-aligned decisions. The non-maskable interrupt, maskable interrupt request, test and reset pins each pass through a multi-stage synchroniser before any logic looks at them. A rising edge on the synchronised non-maskable pin is caught in a sticky latch. The maskable request is a level and is only considered when the core flags an instruction boundary and its interrupt-enable bit is set.

At every instruction boundary, which the core marks with a one-cycle `last_clk` strobe, the block states whether an interrupt sequence must start. It also gives the vector type: a fixed type 2 for the non-maskable source, or 0 with an acknowledge-cycle request for the maskable source. A pending non-maskable event always wins over a maskable request. The core pulses `irq_ack` once it has accepted a non-maskable interrupt, which clears the latch.

The reset pin is qualified: a synchronised reset level must persist for a minimum number of consecutive clocks before `core_reset` is raised. Shorter pulses are dropped. A qualified reset clears the pending interrupt state and blocks interrupt decisions and the stall. While the core runs a wait-for-test instruction, `stall` holds it idle for as long as the synchronised test pin is high.

Top module: `irq_rst_test_ctrl`

## Requirements
- R1: While `pwr_rst_n` is low, and until new pin activity reaches the logic, `take_interrupt`, `need_intack`, `stall` and `core_reset` are 0 and `interrupt_type` is 8'h00.
- R2: Each of the four pins passes through SYNC_STAGES (default 2) flip-flops. A pin level present at clock edge k first affects the outputs in the cycle after edge k+SYNC_STAGES-1. A one-clock pulse therefore shows for exactly one cycle.
- R3: A 0-to-1 change of the synchronised non-maskable pin sets a pending latch in the following cycle. At the next `last_clk` cycle this gives `take_interrupt`=1, `interrupt_type`=8'h02 and `need_intack`=0, whatever the value of `ie_flag`.
- R4: A non-maskable pin held high raises only one pending event. After it is acknowledged, later boundaries see no interrupt until a new 0-to-1 change.
- R5: With the synchronised request high and `ie_flag`=1, a `last_clk` cycle gives `take_interrupt`=1, `interrupt_type`=8'h00 and `need_intack`=1. `take_interrupt` is never 1 outside a `last_clk` cycle.
- R6: When `ie_flag`=0, the maskable request has no effect on any output.
- R7: When a non-maskable event is pending and a maskable request is also valid at the same boundary, the non-maskable source is chosen (type 8'h02, `need_intack`=0).
- R8: `irq_ack` clears the pending non-maskable latch in the next cycle, unless a new rising change arrives in that same cycle, which wins.
- R9: `core_reset` rises after the synchronised reset has been high for MIN_RST_CLKS (default 4) consecutive clocks. It falls one cycle after the synchronised reset goes low. A shorter pulse never raises it.
- R10: While `core_reset` is 1, the pending latch is cleared, and `take_interrupt`, `need_intack` and `stall` are 0.
- R11: `stall` is 1 exactly when `wait_test` is 1 and the synchronised test pin is 1 (and R10 does not block it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| pwr_rst_n | input | 1 | Power-on reset of the conditioner, active low, asynchronous |
| nmi_pin | input | 1 | Raw non-maskable interrupt pin |
| intr_pin | input | 1 | Raw maskable interrupt request pin |
| test_pin | input | 1 | Raw test pin used by wait-for-test |
| reset_pin | input | 1 | Raw system reset pin, active high |
| ie_flag | input | 1 | Core interrupt-enable flag |
| last_clk | input | 1 | Core strobe: last clock of the current instruction |
| wait_test | input | 1 | Core is executing a wait-for-test instruction |
| irq_ack | input | 1 | Core accepted the non-maskable interrupt |
| take_interrupt | output | 1 | Enter an interrupt sequence at this boundary |
| interrupt_type | output | 8 | Vector type: 2 for non-maskable, 0 when supplied by an acknowledge cycle |
| need_intack | output | 1 | Interrupt came from the maskable request; run acknowledge cycles |
| stall | output | 1 | Hold the core idle during wait-for-test |
| core_reset | output | 1 | Qualified, synchronised reset to the core |

## Verification
The checker verifies on every cycle that an interrupt is only taken on a boundary strobe, and that a maskable decision never appears with the enable flag clear. It also checks that a non-maskable decision always carries type 2, that a qualified reset blocks decisions and stall, that stall only appears during a wait-for-test instruction, and that `core_reset` never rises before the raw pin has been high long enough. The synchroniser latency, the single-shot behaviour of a held non-maskable pin, priority between sources, clearing by acknowledge and by reset, and the dropping of short reset pulses depend on event order over many cycles. Only the bench scenarios, compared cycle by cycle against the behavioural model, show these.

// File: rtl/irtc_pkg.sv
package irtc_pkg;
    localparam int PIN_NMI   = 0;
    localparam int PIN_INTR  = 1;
    localparam int PIN_TEST  = 2;
    localparam int PIN_RESET = 3;
    localparam int PIN_COUNT = 4;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_INTR = 2'd2
    } irq_src_e;
endpackage

// File: rtl/irtc_sync.sv
module irtc_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = raw_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irtc_rst_qual.sv
module irtc_rst_qual #(
    parameter int MIN_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req_sync,
    output logic reset_valid
);
    localparam int CW = $clog2(MIN_CLKS + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(MIN_CLKS);

    typedef struct packed {
        logic [CW-1:0] run;
    } qual_t;

    qual_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!req_sync)              st_d.run = '0;
        else if (st_q.run != CNT_MAX) st_d.run = st_q.run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reset_valid = (st_q.run == CNT_MAX);
endmodule

// File: rtl/irtc_arbiter.sv
module irtc_arbiter
    import irtc_pkg::*;
(
    input  logic     boundary,
    input  logic     blocked,
    input  logic     nmi_pending,
    input  logic     intr_level,
    input  logic     ie_flag,
    output irq_src_e src
);
    always_comb begin
        src = SRC_NONE;
        if (boundary && !blocked) begin
            if (nmi_pending)                src = SRC_NMI;
            else if (intr_level && ie_flag) src = SRC_INTR;
        end
    end
endmodule

// File: rtl/irq_rst_test_ctrl.sv
module irq_rst_test_ctrl
    import irtc_pkg::*;
#(
    parameter int          SYNC_STAGES  = 2,
    parameter int          MIN_RST_CLKS = 4,
    parameter int          TYPE_W       = 8,
    parameter logic [7:0]  NMI_TYPE     = 8'h02
) (
    input  logic              clk,
    input  logic              pwr_rst_n,
    input  logic              nmi_pin,
    input  logic              intr_pin,
    input  logic              test_pin,
    input  logic              reset_pin,
    input  logic              ie_flag,
    input  logic              last_clk,
    input  logic              wait_test,
    input  logic              irq_ack,
    output logic              take_interrupt,
    output logic [TYPE_W-1:0] interrupt_type,
    output logic              need_intack,
    output logic              stall,
    output logic              core_reset
);
    localparam logic [TYPE_W-1:0] NMI_VEC = TYPE_W'(NMI_TYPE);

    typedef struct packed {
        logic nmi_prev;
        logic nmi_pend;
    } nmi_state_t;

    logic [PIN_COUNT-1:0] pins_raw, pins_sync;
    logic                 nmi_rise;
    irq_src_e             src;
    nmi_state_t           st_q, st_d;

    always_comb begin
        pins_raw            = '0;
        pins_raw[PIN_NMI]   = nmi_pin;
        pins_raw[PIN_INTR]  = intr_pin;
        pins_raw[PIN_TEST]  = test_pin;
        pins_raw[PIN_RESET] = reset_pin;
    end

    irtc_sync #(.WIDTH(PIN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (pwr_rst_n),
        .raw_i  (pins_raw),
        .sync_o (pins_sync)
    );

    irtc_rst_qual #(.MIN_CLKS(MIN_RST_CLKS)) u_rst (
        .clk         (clk),
        .rst_n       (pwr_rst_n),
        .req_sync    (pins_sync[PIN_RESET]),
        .reset_valid (core_reset)
    );

    assign nmi_rise = pins_sync[PIN_NMI] && !st_q.nmi_prev;

    always_comb begin
        st_d          = st_q;
        st_d.nmi_prev = pins_sync[PIN_NMI];
        if (core_reset)   st_d.nmi_pend = 1'b0;
        else if (nmi_rise) st_d.nmi_pend = 1'b1;
        else if (irq_ack)  st_d.nmi_pend = 1'b0;
    end

    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n) st_q <= '0;
        else            st_q <= st_d;
    end

    irtc_arbiter u_arb (
        .boundary    (last_clk),
        .blocked     (core_reset),
        .nmi_pending (st_q.nmi_pend),
        .intr_level  (pins_sync[PIN_INTR]),
        .ie_flag     (ie_flag),
        .src         (src)
    );

    assign take_interrupt = (src != SRC_NONE);
    assign need_intack    = (src == SRC_INTR);
    assign interrupt_type = (src == SRC_NMI) ? NMI_VEC : '0;
    assign stall          = wait_test && pins_sync[PIN_TEST] && !core_reset;
endmodule

// File: rtl/irtc_chk.sv
module irtc_chk #(
    parameter int         MIN_RST_CLKS = 4,
    parameter int         TYPE_W       = 8,
    parameter logic [7:0] NMI_TYPE     = 8'h02
) (
    input logic              clk,
    input logic              pwr_rst_n,
    input logic              reset_pin,
    input logic              ie_flag,
    input logic              last_clk,
    input logic              wait_test,
    input logic              take_interrupt,
    input logic [TYPE_W-1:0] interrupt_type,
    input logic              need_intack,
    input logic              stall,
    input logic              core_reset
);
    logic [15:0] raw_run_q;

    always_ff @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n)          raw_run_q <= '0;
        else if (!reset_pin)     raw_run_q <= '0;
        else if (raw_run_q != 16'hFFFF) raw_run_q <= raw_run_q + 16'd1;
    end

    // R5
    boundary_only_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        take_interrupt |-> last_clk);

    // R6
    mask_respected_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        need_intack |-> (ie_flag && take_interrupt));

    // R3
    nmi_vector_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        (take_interrupt && !need_intack) |-> (interrupt_type == TYPE_W'(NMI_TYPE)));

    // R10
    reset_blocks_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        core_reset |-> (!take_interrupt && !need_intack && !stall));

    // R11
    stall_scope_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        stall |-> wait_test);

    // R9
    reset_width_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
        $rose(core_reset) |-> (raw_run_q >= 16'(MIN_RST_CLKS)));
endmodule

bind irq_rst_test_ctrl irtc_chk #(
    .MIN_RST_CLKS (MIN_RST_CLKS),
    .TYPE_W       (TYPE_W),
    .NMI_TYPE     (NMI_TYPE)
) u_chk (
    .clk            (clk),
    .pwr_rst_n      (pwr_rst_n),
    .reset_pin      (reset_pin),
    .ie_flag        (ie_flag),
    .last_clk       (last_clk),
    .wait_test      (wait_test),
    .take_interrupt (take_interrupt),
    .interrupt_type (interrupt_type),
    .need_intack    (need_intack),
    .stall          (stall),
    .core_reset     (core_reset)
);

// File: tb/tb_irq_rst_test_ctrl.sv
`timescale 1ns/1ps
module tb_irq_rst_test_ctrl;
    localparam int SYNC = 2;
    localparam int MINR = 4;

    logic clk = 1'b0;
    logic pwr_rst_n = 1'b0;
    logic nmi_pin = 0, intr_pin = 0, test_pin = 0, reset_pin = 0;
    logic ie_flag = 0, last_clk = 0, wait_test = 0, irq_ack = 0;
    logic       take_interrupt, need_intack, stall, core_reset;
    logic [7:0] interrupt_type;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";
    bit    done = 0;

    // behavioural reference state
    int q_nmi[$], q_intr[$], q_test[$], q_rst[$];
    int m_prev, m_pend, m_run;

    always #5 clk = ~clk;

    irq_rst_test_ctrl dut (
        .clk(clk), .pwr_rst_n(pwr_rst_n), .nmi_pin(nmi_pin), .intr_pin(intr_pin),
        .test_pin(test_pin), .reset_pin(reset_pin), .ie_flag(ie_flag),
        .last_clk(last_clk), .wait_test(wait_test), .irq_ack(irq_ack),
        .take_interrupt(take_interrupt), .interrupt_type(interrupt_type),
        .need_intack(need_intack), .stall(stall), .core_reset(core_reset)
    );

    task automatic model_clear();
        q_nmi = {0, 0}; q_intr = {0, 0}; q_test = {0, 0}; q_rst = {0, 0};
        m_prev = 0; m_pend = 0; m_run = 0;
    endtask

    initial model_clear();

    always @(posedge clk or negedge pwr_rst_n) begin
        if (!pwr_rst_n) begin
            model_clear();
        end else begin
            int ns, rs;
            ns = q_nmi[0];
            rs = q_rst[0];
            if (m_run == MINR)         m_pend = 0;
            else if (ns && !m_prev)    m_pend = 1;
            else if (irq_ack)          m_pend = 0;
            m_prev = ns;
            m_run  = rs ? ((m_run < MINR) ? m_run + 1 : MINR) : 0;
            void'(q_nmi.pop_front());  q_nmi.push_back(int'(nmi_pin));
            void'(q_intr.pop_front()); q_intr.push_back(int'(intr_pin));
            void'(q_test.pop_front()); q_test.push_back(int'(test_pin));
            void'(q_rst.pop_front());  q_rst.push_back(int'(reset_pin));
        end
    end

    task automatic check(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            int e_rst, e_take, e_nmi, e_ack, e_stall, e_type;
            e_rst   = (m_run == MINR);
            e_nmi   = last_clk && !e_rst && m_pend;
            e_ack   = last_clk && !e_rst && !m_pend && q_intr[0] && ie_flag;
            e_take  = e_nmi || e_ack;
            e_type  = e_nmi ? 2 : 0;
            e_stall = wait_test && q_test[0] && !e_rst;
            check("take_interrupt", int'(take_interrupt), e_take);
            check("interrupt_type", int'(interrupt_type), e_type);
            check("need_intack",    int'(need_intack),    e_ack);
            check("stall",          int'(stall),          e_stall);
            check("core_reset",     int'(core_reset),     e_rst);
        end
    end

    task automatic tick(int n);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic boundary();
        last_clk = 1; tick(1); last_clk = 0;
    endtask

    task automatic ack();
        irq_ack = 1; tick(1); irq_ack = 0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        tick(3);
        pwr_rst_n = 1;
        tick(3);
        // R11: stall follows synced test during wait-for-test
        cur_req = "R11";
        wait_test = 1; tick(2);
        test_pin = 1;  tick(4);
        test_pin = 0;  tick(4);
        wait_test = 0; test_pin = 1; tick(3); test_pin = 0; tick(3);
        // R2: one-clock pulse latency
        cur_req = "R2";
        wait_test = 1; test_pin = 1; tick(1); test_pin = 0; tick(4); wait_test = 0;
        // R3: nmi edge taken with ie clear
        cur_req = "R3";
        ie_flag = 0; nmi_pin = 1; tick(1); nmi_pin = 0; tick(4);
        boundary(); ack(); tick(2);
        // R4: held nmi fires once
        cur_req = "R4";
        nmi_pin = 1; tick(5); boundary(); ack(); tick(2); boundary(); tick(2);
        nmi_pin = 0; tick(3); boundary();
        // R6: masked request ignored
        cur_req = "R6";
        intr_pin = 1; ie_flag = 0; tick(3); boundary(); tick(2);
        // R5: maskable request taken only at boundary
        cur_req = "R5";
        ie_flag = 1; tick(2); boundary(); tick(1); boundary();
        intr_pin = 0; tick(3); boundary();
        // R7: nmi over intr
        cur_req = "R7";
        intr_pin = 1; nmi_pin = 1; tick(1); nmi_pin = 0; tick(4);
        boundary(); ack(); boundary(); intr_pin = 0; tick(3);
        // R8: ack clears latch; rise beats ack
        cur_req = "R8";
        nmi_pin = 1; tick(1); nmi_pin = 0; tick(4); ack(); tick(1); boundary();
        nmi_pin = 1; tick(2); irq_ack = 1; tick(1); irq_ack = 0; nmi_pin = 0; tick(2);
        boundary(); ack(); tick(2);
        // R9: short reset dropped, long reset qualified
        cur_req = "R9";
        reset_pin = 1; tick(3); reset_pin = 0; tick(5);
        reset_pin = 1; tick(7); boundary(); reset_pin = 0; tick(5);
        // R10: qualified reset clears pending nmi and blocks stall
        cur_req = "R10";
        ie_flag = 0; nmi_pin = 1; tick(1); nmi_pin = 0; tick(4);
        wait_test = 1; test_pin = 1;
        reset_pin = 1; tick(8); boundary(); reset_pin = 0; tick(4);
        boundary(); wait_test = 0; test_pin = 0; tick(3);
        finish_run();
    end
endmodule